// File: doc/BRIEF.md
# SPI Slave Transmit Underrun Guard

This block sits in the transmit path of an SPI slave, between the transmit data buffer and the output shifter. The shifter raises a strobe when it is about to load a new frame. If the buffer has a word, the guard passes it through and pops the buffer. If an underrun has been recognised for that frame, the guard hands the shifter a substitute word and does not pop.

The moment at which an underrun is recognised can be chosen:
- when a frame starts,
- when the previous frame ends, or
- when the slave select becomes active.

The substitute word can be chosen as:
- a programmed pattern,
- the last word received, or
- the last word transmitted.

Each recognised underrun sets a sticky flag. Software clears the flag with a write-one pulse. The flag drives an error interrupt request through an enable.

All inputs are synchronous to `clk`. The reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `spi_tx_underrun_guard`

## Requirements
- R1: With detection code 00 (frame begin), or the reserved code 11, a `frame_start` while `buf_empty` is high is an underrun. That frame loads the substitute, and `udr_flag` reads 1 from the next cycle on.
- R2: With detection code 01 (frame end), a `frame_end` while `buf_empty` is high is an underrun. It sets `udr_flag` next cycle and arms the guard. The next `frame_start` then loads the substitute with `buf_pop` low, even if the buffer has been refilled.
- R3: With detection code 10 (select assert), the select turning active while `buf_empty` is high is an underrun. It sets `udr_flag` and arms the next frame. If a `frame_start` coincides with that edge, that frame takes the substitute and nothing is armed.
- R4: Substitute selection by `cfg_sub_sel`:
  - 00: `cfg_pattern`.
  - 01: `rx_last`.
  - 10: `tx_last`.
  - 11: `cfg_pattern`.
- R5: `udr_flag` is sticky. Only a cycle with `udr_clr` high clears it. An underrun in the same cycle as `udr_clr` wins, and the flag stays set.
- R6: `err_irq` is high exactly when `udr_flag` and `cfg_udr_ie` are both high.
- R7: A `frame_start` that does not take the substitute loads `buf_data` and pulses `buf_pop`. No other cycle pops. Normal data resumes at the first such frame after an underrun.
- R8: `cfg_ss_act_high` = 1 makes a high `ss_level` the active select level. `cfg_ss_act_high` = 0 makes a low level active.
- R9: While the select is inactive the armed state is dropped. A `frame_start` with a filled buffer after reselection passes buffer data.
- R10: A `frame_start` with `buf_empty` high always loads the substitute. When that moment is not the configured detection point, `udr_flag` is not set.
- R11: `udr_flag` is 0 in reset. Underrun inputs on the first two clock edges after `rst_n` rises have no effect on `udr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_level | input | 1 | Slave-select pin level |
| cfg_ss_act_high | input | 1 | 1: select active high; 0: active low |
| cfg_det_sel | input | 2 | Detection point: 00 begin, 01 end, 10 select assert, 11 as 00 |
| cfg_sub_sel | input | 2 | Substitute: 00 pattern, 01 last rx, 10 last tx, 11 pattern |
| cfg_pattern | input | DATA_W | Programmed substitute pattern |
| cfg_udr_ie | input | 1 | Underrun interrupt enable |
| udr_clr | input | 1 | Write-one clear pulse for the flag |
| frame_start | input | 1 | Shifter loads a new frame this cycle |
| frame_end | input | 1 | Shifter completes a frame this cycle |
| buf_empty | input | 1 | Transmit buffer empty |
| buf_data | input | DATA_W | Head word of the transmit buffer |
| rx_last | input | DATA_W | Last received word |
| tx_last | input | DATA_W | Last transmitted word |
| load_data | output | DATA_W | Word presented to the shifter on `frame_start` |
| load_sub | output | 1 | The current frame loads the substitute |
| buf_pop | output | 1 | Pop the transmit buffer |
| udr_flag | output | 1 | Sticky underrun flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
Directed sequences place an empty buffer at each of the three detection moments. Refilling the buffer before the following frame shows whether the armed state, rather than the live buffer status, decides the substitution. Each substitute code is exercised, along with:
- a flag clear that coincides with a new underrun,
- deselection while armed,
- both select polarities,
- frame-start underruns outside the configured detection point.

A long stretch of pseudo-random strobes, select toggling and configuration changes is then compared every cycle against a behavioural model. This exposes ordering cases such as a frame end and a frame start in the same cycle.

// File: rtl/udr_pkg.sv
`timescale 1ns/1ps
package udr_pkg;

  typedef enum logic [1:0] {
    DET_FRAME_BEGIN = 2'b00,
    DET_FRAME_END   = 2'b01,
    DET_SEL_ASSERT  = 2'b10,
    DET_RESERVED    = 2'b11
  } det_point_e;

  typedef enum logic [1:0] {
    SUB_PATTERN = 2'b00,
    SUB_LAST_RX = 2'b01,
    SUB_LAST_TX = 2'b10,
    SUB_RESERVED = 2'b11
  } sub_policy_e;

  localparam int RST_STAGES = 2;

endpackage

// File: rtl/udr_rst_sync.sv
`timescale 1ns/1ps
module udr_rst_sync import udr_pkg::*; (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);
  logic [RST_STAGES-1:0] pipe_q;
  logic [RST_STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_q = pipe_q[RST_STAGES-1];
endmodule

// File: rtl/udr_sel_edge.sv
`timescale 1ns/1ps
module udr_sel_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_level,
  input  logic act_high,
  output logic sel_active,
  output logic sel_rise
);
  logic act_q;
  logic act_d;

  always_comb begin
    sel_active = act_high ? ss_level : ~ss_level;
    act_d      = sel_active;
    sel_rise   = sel_active & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end
endmodule

// File: rtl/udr_detect.sv
`timescale 1ns/1ps
module udr_detect import udr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] det_sel,
  input  logic       frame_start,
  input  logic       frame_end,
  input  logic       buf_empty,
  input  logic       sel_active,
  input  logic       sel_rise,
  output logic       udr_event,
  output logic       use_sub
);
  det_point_e mode;
  logic       arm_q;
  logic       arm_d;
  logic       arm_en;
  logic       defers;

  always_comb begin
    mode = det_point_e'(det_sel);
    unique case (mode)
      DET_FRAME_END:  udr_event = frame_end & buf_empty;
      DET_SEL_ASSERT: udr_event = sel_rise & buf_empty;
      default:        udr_event = frame_start & buf_empty;
    endcase
    // a deferred event applies to the next frame, except when a frame
    // starts together with the select edge and consumes it at once
    defers  = (mode == DET_FRAME_END) |
              ((mode == DET_SEL_ASSERT) & ~frame_start);
    use_sub = frame_start & (arm_q | buf_empty);

    arm_d = arm_q;
    if (frame_start)         arm_d = 1'b0;
    if (udr_event && defers) arm_d = 1'b1;
    if (!sel_active)         arm_d = 1'b0;
    arm_en = (arm_d != arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end
endmodule

// File: rtl/udr_subst.sv
`timescale 1ns/1ps
module udr_subst import udr_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sub_sel,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] rx_last,
  input  logic [DATA_W-1:0] tx_last,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              use_sub,
  output logic [DATA_W-1:0] load_data
);
  sub_policy_e         pol;
  logic [DATA_W-1:0]   sub_word;

  always_comb begin
    pol = sub_policy_e'(sub_sel);
    unique case (pol)
      SUB_LAST_RX: sub_word = rx_last;
      SUB_LAST_TX: sub_word = tx_last;
      default:     sub_word = pattern;
    endcase
    load_data = use_sub ? sub_word : buf_data;
  end
endmodule

// File: rtl/udr_flag.sv
`timescale 1ns/1ps
module udr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set | clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & ie;
endmodule

// File: rtl/spi_tx_underrun_guard.sv
`timescale 1ns/1ps
module spi_tx_underrun_guard import udr_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_level,
  input  logic              cfg_ss_act_high,
  input  logic [1:0]        cfg_det_sel,
  input  logic [1:0]        cfg_sub_sel,
  input  logic [DATA_W-1:0] cfg_pattern,
  input  logic              cfg_udr_ie,
  input  logic              udr_clr,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] buf_data,
  input  logic [DATA_W-1:0] rx_last,
  input  logic [DATA_W-1:0] tx_last,
  output logic [DATA_W-1:0] load_data,
  output logic              load_sub,
  output logic              buf_pop,
  output logic              udr_flag,
  output logic              err_irq
);
  logic rst_q;
  logic sel_active;
  logic sel_rise;
  logic udr_event;
  logic use_sub;

  udr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_q  (rst_q)
  );

  udr_sel_edge u_sel (
    .clk        (clk),
    .rst_n      (rst_q),
    .ss_level   (ss_level),
    .act_high   (cfg_ss_act_high),
    .sel_active (sel_active),
    .sel_rise   (sel_rise)
  );

  udr_detect u_det (
    .clk         (clk),
    .rst_n       (rst_q),
    .det_sel     (cfg_det_sel),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .buf_empty   (buf_empty),
    .sel_active  (sel_active),
    .sel_rise    (sel_rise),
    .udr_event   (udr_event),
    .use_sub     (use_sub)
  );

  udr_subst #(.DATA_W(DATA_W)) u_sub (
    .sub_sel   (cfg_sub_sel),
    .pattern   (cfg_pattern),
    .rx_last   (rx_last),
    .tx_last   (tx_last),
    .buf_data  (buf_data),
    .use_sub   (use_sub),
    .load_data (load_data)
  );

  udr_flag u_flag (
    .clk   (clk),
    .rst_n (rst_q),
    .set   (udr_event),
    .clr   (udr_clr),
    .ie    (cfg_udr_ie),
    .flag  (udr_flag),
    .irq   (err_irq)
  );

  assign load_sub = use_sub;
  assign buf_pop  = frame_start & ~use_sub;
endmodule

// File: rtl/spi_tx_underrun_guard_chk.sv
`timescale 1ns/1ps
module spi_tx_underrun_guard_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        det_sel,
  input logic [1:0]        sub_sel,
  input logic [DATA_W-1:0] pattern,
  input logic [DATA_W-1:0] rx_last,
  input logic [DATA_W-1:0] tx_last,
  input logic              ie,
  input logic              clr,
  input logic              frame_start,
  input logic              frame_end,
  input logic              buf_empty,
  input logic [DATA_W-1:0] load_data,
  input logic              load_sub,
  input logic              buf_pop,
  input logic              udr_flag,
  input logic              err_irq
);
  AST_BEGIN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sel[0] == det_sel[1]) && frame_start && buf_empty |=> udr_flag); // R1
  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sel == 2'b01) && frame_end && buf_empty |=> udr_flag); // R2
  AST_PATTERN_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && load_sub && (sub_sel[0] == sub_sel[1]) |-> load_data == pattern); // R4
  AST_RX_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && load_sub && (sub_sel == 2'b01) |-> load_data == rx_last); // R4
  AST_TX_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && load_sub && (sub_sel == 2'b10) |-> load_data == tx_last); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    udr_flag && !clr |=> udr_flag); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !err_irq); // R6
  AST_POP_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> frame_start && !buf_empty && !load_sub); // R7
  AST_EMPTY_SUBSTITUTES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && buf_empty |-> load_sub); // R10
endmodule

bind spi_tx_underrun_guard spi_tx_underrun_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .det_sel     (cfg_det_sel),
  .sub_sel     (cfg_sub_sel),
  .pattern     (cfg_pattern),
  .rx_last     (rx_last),
  .tx_last     (tx_last),
  .ie          (cfg_udr_ie),
  .clr         (udr_clr),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .buf_empty   (buf_empty),
  .load_data   (load_data),
  .load_sub    (load_sub),
  .buf_pop     (buf_pop),
  .udr_flag    (udr_flag),
  .err_irq     (err_irq)
);

// File: tb/spi_tx_underrun_guard_tb_top.sv
`timescale 1ns/1ps
module spi_tx_underrun_guard_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic ss_level, act_high, ie, clr, fs, fe, empty;
  logic [1:0] det, sub;
  logic [W-1:0] pat, bdata, rxw, txw;
  logic [W-1:0] load_data;
  logic load_sub, buf_pop, udr_flag, err_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_tx_underrun_guard #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ss_level(ss_level), .cfg_ss_act_high(act_high),
    .cfg_det_sel(det), .cfg_sub_sel(sub), .cfg_pattern(pat), .cfg_udr_ie(ie),
    .udr_clr(clr), .frame_start(fs), .frame_end(fe), .buf_empty(empty),
    .buf_data(bdata), .rx_last(rxw), .tx_last(txw), .load_data(load_data),
    .load_sub(load_sub), .buf_pop(buf_pop), .udr_flag(udr_flag), .err_irq(err_irq)
  );

  // behavioural reference model
  int  live_cnt;
  bit  m_flag, m_arm, m_ssq;

  function automatic bit sel_on();
    return act_high ? ss_level : !ss_level;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt = 0; m_flag = 0; m_arm = 0; m_ssq = 0;
    end else if (live_cnt < 2) begin
      live_cnt = live_cnt + 1;
    end else begin
      bit ev, on, rise;
      on = sel_on();
      rise = on && !m_ssq;
      case (det)
        2'b01:   ev = fe && empty;
        2'b10:   ev = rise && empty;
        default: ev = fs && empty;
      endcase
      if (ev) m_flag = 1;
      else if (clr) m_flag = 0;
      if (!on) m_arm = 0;
      else if (ev && (det == 2'b01 || (det == 2'b10 && !fs))) m_arm = 1;
      else if (fs) m_arm = 0;
      m_ssq = on;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit es;
      logic [W-1:0] ed;
      es = fs && (m_arm || empty);
      ed = !es ? bdata : (sub == 2'b01 ? rxw : (sub == 2'b10 ? txw : pat));
      chk("R1 load_sub", {31'b0, load_sub}, {31'b0, es});
      chk("R7 buf_pop", {31'b0, buf_pop}, {31'b0, fs && !es});
      chk("R5 udr_flag", {31'b0, udr_flag}, {31'b0, m_flag});
      chk("R6 err_irq", {31'b0, err_irq}, {31'b0, m_flag && ie});
      if (fs) chk("R4 load_data", load_data, ed);
    end
  end

  task automatic tick();
    @(posedge clk); #0.5;
    fs = 0; fe = 0; clr = 0;
  endtask

  task automatic peek(); #0.5; endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ss_level = 1; act_high = 0; ie = 0; clr = 0; fs = 0; fe = 0;
    empty = 0; det = 2'b00; sub = 2'b00;
    pat = 32'hA5A5_0F0F; bdata = 32'h1111_2222; rxw = 32'hCAFE_0001; txw = 32'hBEEF_0002;
    repeat (3) @(posedge clk);
    #0.5;
    chk("R11 reset flag", {31'b0, udr_flag}, 32'd0);
    chk("R11 reset irq", {31'b0, err_irq}, 32'd0);
    rst_n = 1;
    ss_level = 0; empty = 1; fs = 1;
    @(posedge clk); #0.5;
    @(posedge clk); #0.5;
    fs = 0; empty = 0;
    peek();
    chk("R11 edges during release ignored", {31'b0, udr_flag}, 32'd0);
    tick(); tick();

    // R7 normal data
    fs = 1; peek();
    chk("R7 pop", {31'b0, buf_pop}, 32'd1);
    chk("R7 data", load_data, 32'h1111_2222);
    tick(); peek();
    chk("R7 no flag", {31'b0, udr_flag}, 32'd0);

    // R1 frame-begin detection
    empty = 1; fs = 1; peek();
    chk("R1 sub used", {31'b0, load_sub}, 32'd1);
    chk("R4 pattern", load_data, pat);
    tick(); peek();
    chk("R1 flag set", {31'b0, udr_flag}, 32'd1);
    chk("R6 irq masked", {31'b0, err_irq}, 32'd0);
    ie = 1; peek();
    chk("R6 irq on", {31'b0, err_irq}, 32'd1);
    tick(); tick(); peek();
    chk("R5 sticky", {31'b0, udr_flag}, 32'd1);
    clr = 1; tick(); peek();
    chk("R5 cleared", {31'b0, udr_flag}, 32'd0);
    fs = 1; clr = 1; tick(); peek();
    chk("R5 set beats clear", {31'b0, udr_flag}, 32'd1);

    // R4 policies
    sub = 2'b01; fs = 1; peek(); chk("R4 last rx", load_data, rxw); tick();
    sub = 2'b10; fs = 1; peek(); chk("R4 last tx", load_data, txw); tick();
    sub = 2'b11; fs = 1; peek(); chk("R4 reserved->pattern", load_data, pat); tick();
    sub = 2'b00;

    // R2 frame-end detection
    det = 2'b01; clr = 1; tick();
    fs = 1; peek();
    chk("R10 sub without detection", {31'b0, load_sub}, 32'd1);
    tick(); peek();
    chk("R10 no flag", {31'b0, udr_flag}, 32'd0);
    fe = 1; tick(); empty = 0; peek();
    chk("R2 flag", {31'b0, udr_flag}, 32'd1);
    tick(); fs = 1; peek();
    chk("R2 sub despite refill", {31'b0, load_sub}, 32'd1);
    chk("R2 no pop", {31'b0, buf_pop}, 32'd0);
    tick(); fs = 1; peek();
    chk("R7 resume data", load_data, bdata);
    tick();

    // R9 deselect drops arm
    empty = 1; fe = 1; tick(); empty = 0;
    ss_level = 1; tick(); ss_level = 0; tick();
    fs = 1; peek();
    chk("R9 arm dropped", {31'b0, load_sub}, 32'd0);
    tick();

    // R3 select-assert detection
    det = 2'b10; clr = 1; ss_level = 1; tick();
    empty = 1; ss_level = 0; tick(); empty = 0; peek();
    chk("R3 flag", {31'b0, udr_flag}, 32'd1);
    fs = 1; peek();
    chk("R3 armed frame", {31'b0, load_sub}, 32'd1);
    tick(); clr = 1; tick();
    ss_level = 1; tick(); ss_level = 0; tick(); peek();
    chk("R3 filled select no flag", {31'b0, udr_flag}, 32'd0);

    // R8 active-high polarity
    act_high = 1; ss_level = 0; tick();
    empty = 1; ss_level = 1; tick(); empty = 0; peek();
    chk("R8 active-high edge", {31'b0, udr_flag}, 32'd1);
    clr = 1; tick();

    // pseudo-random stretch, checked every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) begin
        det = 2'($urandom); sub = 2'($urandom);
        act_high = 1'($urandom); ie = 1'($urandom);
      end
      ss_level = ($urandom % 8 == 0) ? !ss_level : ss_level;
      fs = ($urandom % 3 == 0);
      fe = ($urandom % 3 == 0);
      empty = ($urandom % 2 == 0);
      clr = ($urandom % 10 == 0);
      bdata = $urandom; rxw = $urandom; txw = $urandom; pat = $urandom;
      @(posedge clk); #0.5;
    end
    fs = 0; fe = 0; clr = 0;
    tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule